// File: doc/BRIEF.md
# Event-Driven Leaky State Update

This block keeps a small vector of signed 8-bit state elements and advances it only when an input event arrives. Each event carries a timestamp and one precomputed input value per element. When an event is accepted, the block measures the gap since the previous accepted event and looks up a decay factor for that gap. It scales every stored element by that factor, adds the matching input value, and clamps the result to the 8-bit range. When the whole vector has been rewritten, the block raises a one-cycle completion pulse.

All elements share one decay rate, which is fixed by a parameter. The factor for a gap of k ticks is the per-tick ratio raised to the k-th power, stored as a fixed-point fraction. The elements are processed one per clock cycle through a single arithmetic datapath. Between events nothing is computed and the stored vector holds its value. A synchronous clear input returns the block to its post-reset condition.

Top module: `evt_state_update`

## Requirements
- R1: After reset every state element reads zero, `out_valid` is low and `evt_ready` is high.
- R2: An event is taken only on a cycle where `evt_valid` and `evt_ready` are both high. `evt_ready` stays low from the acceptance edge until the completion pulse. While it is low, `evt_valid`, `evt_ts` and `evt_proj` have no effect on the result or on later gap measurements.
- R3: The gap dt is (`evt_ts` minus the timestamp of the previous accepted event) modulo 2^TSW. The remembered timestamp is replaced on every accepted event and starts at zero.
- R4: The decay factor has FRAC+1 bits and is built up from F(0) = 2^FRAC. For each k below 2^DT_BITS, F(k) = floor((F(k-1)*RATIO + 2^(FRAC-1)) / 2^FRAC). For dt of 2^DT_BITS or more, F = 0.
- R5: Each element s with input x becomes clamp(floor((s*F + 2^(FRAC-1)) / 2^FRAC) + x) to [-2^(DW-1), 2^(DW-1)-1]. All values are two's complement.
- R6: Elements are rewritten one per cycle. `out_valid` is a one-cycle pulse that is high in the cycle after the N_ELEM-th rising edge following the acceptance edge. `evt_ready` is high again while the pulse is high.
- R7: `clr` takes priority over everything else. At the next edge it zeroes every element and the remembered timestamp, abandons an update in progress (no completion pulse follows) and leaves the block ready.
- R8: Element i of `out_state` occupies bits [DW*i+DW-1 : DW*i] and element i of `evt_proj` uses the same bit positions. The new value of element i depends only on its own old value and input i.
- R9: When no event is accepted and `clr` is low, `out_state` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| clr | input | 1 | Synchronous clear of state and remembered timestamp |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Block can take an event |
| evt_ts | input | TSW | Event timestamp in ticks |
| evt_proj | input | N_ELEM*DW | Projected input values, element i in bits [DW*i+DW-1 : DW*i] |
| out_valid | output | 1 | One-cycle pulse when the state vector has been fully updated |
| out_state | output | N_ELEM*DW | Current state vector, same packing as `evt_proj` |

## Verification
The assertions assume that `evt_valid` is held low for a few cycles after `rst_n` rises, while the internal reset synchronizer is still holding the registers. They also assume that `clr` is not raised while `rst_n` is low. The stimulus applies a reset pulse, idles through the synchronizer delay, and only then offers events. Events are driven on falling edges and the pulses are spaced so that each one meets these conditions. The stimulus also deliberately offers events while the block is busy, to show that they are ignored, and raises `clr` partway through an update.

// File: rtl/evt_su_pkg.sv
package evt_su_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Fixed-point power of the per-tick ratio, rounded at every step.
  function automatic int decay_power(input int steps, input int ratio, input int frac);
    int f;
    f = 1 << frac;
    for (int i = 0; i < steps; i++) begin
      f = (f * ratio + (1 << (frac - 1))) >> frac;
    end
    return f;
  endfunction

endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/evt_dt_lookup.sv
module evt_dt_lookup
  import evt_su_pkg::*;
#(
  parameter int TSW     = 16,
  parameter int DT_BITS = 4,
  parameter int FRAC    = 8,
  parameter int RATIO   = 230
) (
  input  logic [TSW-1:0]  ts_now,
  input  logic [TSW-1:0]  ts_last,
  output logic [FRAC:0]   factor
);
  localparam int FW      = FRAC + 1;
  localparam int TBL_LEN = 1 << DT_BITS;

  logic [TSW-1:0] gap;
  logic           in_range;
  logic [FW-1:0]  tbl [TBL_LEN];

  for (genvar g = 0; g < TBL_LEN; g++) begin : g_tbl
    assign tbl[g] = FW'(decay_power(g, RATIO, FRAC));
  end

  always_comb begin
    gap      = ts_now - ts_last;
    in_range = ~|gap[TSW-1:DT_BITS];
    factor   = in_range ? tbl[gap[DT_BITS-1:0]] : '0;
  end
endmodule

// File: rtl/evt_elem_update.sv
module evt_elem_update #(
  parameter int DW   = 8,
  parameter int FRAC = 8
) (
  input  logic signed [DW-1:0] st,
  input  logic signed [DW-1:0] x,
  input  logic        [FRAC:0] factor,
  output logic        [DW-1:0] nxt
);
  localparam int PW = DW + FRAC + 2;
  localparam int SW = DW + 2;
  localparam logic signed [SW-1:0] VMAX = SW'((1 << (DW - 1)) - 1);
  localparam logic signed [SW-1:0] VMIN = SW'(-(1 << (DW - 1)));

  logic signed [PW-1:0] st_w, fac_w, prod, rnd, dec;
  logic signed [SW-1:0] dec_s, x_s, sum;

  always_comb begin
    st_w  = PW'(st);
    fac_w = signed'(PW'(factor));
    prod  = st_w * fac_w;
    rnd   = prod + PW'(1 << (FRAC - 1));
    dec   = rnd >>> FRAC;
    dec_s = SW'(dec);
    x_s   = SW'(x);
    sum   = dec_s + x_s;
    if (sum > VMAX)      nxt = VMAX[DW-1:0];
    else if (sum < VMIN) nxt = VMIN[DW-1:0];
    else                 nxt = sum[DW-1:0];
  end
endmodule

// File: rtl/evt_seq_ctrl.sv
module evt_seq_ctrl
  import evt_su_pkg::*;
#(
  parameter int N_ELEM = 4,
  parameter int IW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  output logic          busy,
  output logic [IW-1:0] idx,
  output logic          done
);
  localparam logic [IW-1:0] LAST = IW'(N_ELEM - 1);

  seq_state_e    st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          done_q, done_d;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    if (clr) begin
      st_d  = SEQ_IDLE;
      idx_d = '0;
    end else if (start) begin
      st_d  = SEQ_RUN;
      idx_d = '0;
    end else if (st_q == SEQ_RUN) begin
      if (idx_q == LAST) begin
        st_d   = SEQ_IDLE;
        idx_d  = '0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign busy = (st_q == SEQ_RUN);
  assign idx  = idx_q;
  assign done = done_q;
endmodule

// File: rtl/evt_state_update.sv
module evt_state_update #(
  parameter int N_ELEM  = 4,
  parameter int DW      = 8,
  parameter int TSW     = 16,
  parameter int DT_BITS = 4,
  parameter int FRAC    = 8,
  parameter int RATIO   = 230
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 evt_valid,
  output logic                 evt_ready,
  input  logic [TSW-1:0]       evt_ts,
  input  logic [N_ELEM*DW-1:0] evt_proj,
  output logic                 out_valid,
  output logic [N_ELEM*DW-1:0] out_state
);
  localparam int IW = (N_ELEM > 1) ? $clog2(N_ELEM) : 1;
  localparam int FW = FRAC + 1;
  localparam int VW = N_ELEM * DW;

  logic          rst_i_n;
  logic          busy, start;
  logic [IW-1:0] idx;
  logic          done;

  logic [TSW-1:0] last_ts_q, last_ts_d;
  logic           last_ts_en;
  logic [FW-1:0]  fac_q, fac_lut;
  logic [VW-1:0]  proj_q;
  logic           load_en;

  logic [DW-1:0]  state_q  [N_ELEM];
  logic [DW-1:0]  state_d  [N_ELEM];
  logic           state_en [N_ELEM];
  logic [DW-1:0]  proj_el  [N_ELEM];
  logic [DW-1:0]  upd;

  evt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign evt_ready = ~busy;
  assign start     = evt_valid & evt_ready & ~clr;

  evt_seq_ctrl #(.N_ELEM(N_ELEM), .IW(IW)) u_seq (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (clr),
    .start (start),
    .busy  (busy),
    .idx   (idx),
    .done  (done)
  );

  evt_dt_lookup #(.TSW(TSW), .DT_BITS(DT_BITS), .FRAC(FRAC), .RATIO(RATIO)) u_lut (
    .ts_now  (evt_ts),
    .ts_last (last_ts_q),
    .factor  (fac_lut)
  );

  // Event capture: timestamp, factor and input vector.
  always_comb begin
    load_en    = start;
    last_ts_en = start | clr;
    last_ts_d  = clr ? '0 : evt_ts;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)        last_ts_q <= '0;
    else if (last_ts_en) last_ts_q <= last_ts_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      fac_q  <= '0;
      proj_q <= '0;
    end else if (load_en) begin
      fac_q  <= fac_lut;
      proj_q <= evt_proj;
    end
  end

  // Shared element datapath, one element per cycle.
  evt_elem_update #(.DW(DW), .FRAC(FRAC)) u_elem (
    .st     (state_q[idx]),
    .x      (proj_el[idx]),
    .factor (fac_q),
    .nxt    (upd)
  );

  for (genvar g = 0; g < N_ELEM; g++) begin : g_elem
    assign proj_el[g]               = proj_q[g*DW +: DW];
    assign out_state[g*DW +: DW]    = state_q[g];

    always_comb begin
      state_en[g] = clr | (busy & (idx == IW'(g)));
      state_d[g]  = clr ? '0 : upd;
    end

    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n)         state_q[g] <= '0;
      else if (state_en[g]) state_q[g] <= state_d[g];
    end
  end

  assign out_valid = done;
endmodule

// File: rtl/evt_state_update_chk.sv
module evt_state_update_chk #(
  parameter int N_ELEM = 4,
  parameter int DW     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clr,
  input logic                 evt_valid,
  input logic                 evt_ready,
  input logic                 out_valid,
  input logic [N_ELEM*DW-1:0] out_state
);
  localparam int CW = $clog2(N_ELEM + 2) + 1;
  logic [CW-1:0] since_q;
  logic          acc;

  assign acc = evt_valid & evt_ready & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_q <= '0;
    else if (clr)            since_q <= '0;
    else if (acc)            since_q <= CW'(1);
    else if (out_valid)      since_q <= '0;
    else if (since_q != '0)  since_q <= since_q + CW'(1);
  end

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !evt_ready); // R2
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (since_q == CW'(N_ELEM + 1))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R6
  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> evt_ready); // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (out_state == '0 && evt_ready && !out_valid)); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ready && !evt_valid && !clr) |=> $stable(out_state)); // R9
endmodule

bind evt_state_update evt_state_update_chk #(.N_ELEM(N_ELEM), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .evt_valid (evt_valid),
  .evt_ready (evt_ready),
  .out_valid (out_valid),
  .out_state (out_state)
);

// File: tb/tb_evt_state_update.sv
`timescale 1ns/1ps
module tb_evt_state_update;
  localparam int N    = 4;
  localparam int DW   = 8;
  localparam int TSW  = 16;
  localparam int DTB  = 4;
  localparam int FRAC = 8;
  localparam int RAT  = 230;

  logic clk = 1'b0;
  logic rst_n, clr, evt_valid;
  logic evt_ready, out_valid;
  logic [TSW-1:0]  evt_ts;
  logic [N*DW-1:0] evt_proj, out_state;

  int total = 0;
  int bad   = 0;
  int mdl [N];
  int mdl_last = 0;
  int cur = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  evt_state_update #(.N_ELEM(N), .DW(DW), .TSW(TSW), .DT_BITS(DTB),
                     .FRAC(FRAC), .RATIO(RAT)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_ts(evt_ts), .evt_proj(evt_proj),
    .out_valid(out_valid), .out_state(out_state));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fac_of(input int dt);
    int f;
    if (dt >= (1 << DTB)) return 0;
    f = 1 << FRAC;
    for (int i = 0; i < dt; i++) f = (f * RAT + (1 << (FRAC - 1))) >> FRAC;
    return f;
  endfunction

  function automatic int sat8(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int elem(input int i);
    return int'($signed(out_state[i*DW +: DW]));
  endfunction

  task automatic model_apply(input int ts, input int xs[N]);
    int dt, f;
    dt = (ts - mdl_last) & 16'hFFFF;
    f  = fac_of(dt);
    for (int i = 0; i < N; i++)
      mdl[i] = sat8(((mdl[i] * f + (1 << (FRAC - 1))) >>> FRAC) + xs[i]);
    mdl_last = ts & 16'hFFFF;
  endtask

  task automatic compare(input string req);
    for (int i = 0; i < N; i++) check(req, elem(i), mdl[i]);
  endtask

  task automatic drive_proj(input int xs[N]);
    for (int i = 0; i < N; i++) evt_proj[i*DW +: DW] = xs[i][DW-1:0];
  endtask

  // Offers one event, optionally pokes a competing event while busy.
  task automatic send(input int ts, input int xs[N], input bit poke, input string req);
    int lat;
    bit rdy_seen;
    @(negedge clk);
    while (!evt_ready) @(negedge clk);
    evt_valid = 1'b1;
    evt_ts    = ts[TSW-1:0];
    drive_proj(xs);
    @(negedge clk);
    evt_valid = 1'b0;
    model_apply(ts, xs);
    lat = 0;
    rdy_seen = 1'b0;
    while (!out_valid) begin
      if (evt_ready) rdy_seen = 1'b1;
      if (poke && lat == 1) begin
        evt_valid = 1'b1;
        evt_ts    = ts[TSW-1:0] + 16'd7;
        evt_proj  = '1;
      end else begin
        evt_valid = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    evt_valid = 1'b0;
    check("R2 busy", int'(rdy_seen), 0);
    check("R6 latency", lat, N);
    compare(req);
    @(negedge clk);
    check("R6 pulse", int'(out_valid), 0);
  endtask

  initial begin
    int xs[N];
    int snap [N];
    int seen;
    rst_n = 1'b0; clr = 1'b0; evt_valid = 1'b0; evt_ts = '0; evt_proj = '0;
    for (int i = 0; i < N; i++) mdl[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset condition
    check("R1 ready", int'(evt_ready), 1);
    check("R1 valid", int'(out_valid), 0);
    compare("R1");

    // R3 R4 R8: gap sweep with distinct per-element inputs
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < N; i++) xs[i] = ((k * 37 + i * 53) % 256) - 128;
      cur += k % 20;
      send(cur, xs, 1'b0, "R8");
    end

    // R5: near-exhaustive decay and rounding sweep over state values
    for (int s = -128; s < 128; s++) begin
      xs[0] = s; xs[1] = -1 - s; xs[2] = s / 2; xs[3] = (s * 3) % 128;
      cur += 20;
      send(cur, xs, 1'b0, "R5 load");
      for (int i = 0; i < N; i++) xs[i] = 0;
      cur += (s + 128) % 18;
      send(cur, xs, 1'b0, "R5 decay");
    end

    // R5: saturation at both ends with no decay
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < N; i++) xs[i] = (i % 2 == 0) ? 100 : -100;
      send(cur, xs, 1'b0, "R5 sat");
    end
    check("R5 sat hi", elem(0), 127);
    check("R5 sat lo", elem(1), -128);

    // R3: timestamp wraparound
    cur = 65530;
    for (int i = 0; i < N; i++) xs[i] = 90 - i * 40;
    send(cur, xs, 1'b0, "R3 pre");
    for (int i = 0; i < N; i++) xs[i] = 0;
    cur = 65536 + 3;
    send(cur, xs, 1'b0, "R3 wrap");

    // R2: event offered while busy is ignored
    for (int i = 0; i < N; i++) xs[i] = 20 * i - 30;
    cur = 3 + 2;
    send(cur, xs, 1'b1, "R2 ignore");
    for (int i = 0; i < N; i++) xs[i] = 1;
    cur += 5;
    send(cur, xs, 1'b0, "R2 gap");

    // R9: idle hold
    for (int i = 0; i < N; i++) snap[i] = elem(i);
    repeat (20) @(negedge clk);
    for (int i = 0; i < N; i++) check("R9", elem(i), snap[i]);

    // R7: clear while idle
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    for (int i = 0; i < N; i++) mdl[i] = 0;
    mdl_last = 0;
    compare("R7 idle");
    check("R7 ready", int'(evt_ready), 1);

    // R7: clear aborts an update in progress
    for (int i = 0; i < N; i++) xs[i] = 50;
    cur = 9;
    send(cur, xs, 1'b0, "R7 setup");
    @(negedge clk);
    evt_valid = 1'b1; evt_ts = 16'd12; drive_proj(xs);
    @(negedge clk);
    evt_valid = 1'b0;
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    seen = 0;
    for (int c = 0; c < 8; c++) begin
      if (out_valid) seen++;
      @(negedge clk);
    end
    check("R7 no pulse", seen, 0);
    for (int i = 0; i < N; i++) mdl[i] = 0;
    mdl_last = 0;
    compare("R7 abort");

    // R3: remembered timestamp restarts at zero after clear
    for (int i = 0; i < N; i++) xs[i] = 64 - 30 * i;
    send(20, xs, 1'b0, "R3 clr load");
    for (int i = 0; i < N; i++) xs[i] = 0;
    send(23, xs, 1'b0, "R3 clr gap");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule